// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steers a processor subsystem through six operating modes: normal, idle, deep idle, standby, sleep and deep sleep. Every mode other than normal is a low-power mode. Software asks for a mode change with a one-cycle request. The sequencer then drives the CPU clock enable, the PLL enable, and the low-voltage and high-voltage supply enables to match the chosen mode. It holds them there until an exit condition arrives.

The exit path depends on the mode. Idle and deep idle resume on an interrupt or on a wake event. Standby resumes only on a wake event. Sleep and deep sleep cannot resume, because the core state is lost. On a wake event the supplies come back first, then the PLL, and a reboot request is held until a programmable settle count runs out, so that fetch restarts at address zero. Deep idle is granted only while the core is running at the low-frequency setting.

Wake events come from 37 asynchronous inputs, each with its own enable bit. A cause register records which input woke the part.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, cur_mode is 0 (normal), cpu_clk_en, pll_en, lv_supply_en and hv_supply_en are 1, and reboot_req, busy and cause_valid are 0.
- R2: Mode codes are 0 normal, 1 idle, 2 deep idle, 3 standby, 4 sleep, 5 deep sleep. In normal mode, req_valid sampled high at a clock edge with a code from 1 to 5 moves cur_mode to that code at that edge. Code 0 leaves the mode unchanged, and so do codes 6 and 7.
- R3: In idle and deep idle, cpu_clk_en is 0 and pll_en, lv_supply_en and hv_supply_en are 1. An irq sampled high returns the block to normal at that edge, and so does a wake event.
- R4: A deep-idle request made while core_low_freq is 0 is refused, and the block stays in normal. With core_low_freq at 1 the request is granted.
- R5: In standby, cpu_clk_en and pll_en are 0 and both supply enables are 1. irq has no effect. A wake event returns the block directly to normal, with reboot_req staying 0.
- R6: In sleep, cpu_clk_en, pll_en and lv_supply_en are 0 and hv_supply_en is 1. In deep sleep all four are 0. irq has no effect in either mode.
- R7: A wake event in sleep or deep sleep starts a settle phase that lasts L+1 cycles, where L is settle_cycles, or 1 when settle_cycles is 0. During the settle phase, busy and reboot_req are 1, both supply enables are 1, cpu_clk_en is 0, and cur_mode still shows the mode being left. pll_en is 0 in the first settle cycle and 1 in the rest. After the settle phase the block is in normal with reboot_req 0.
- R8: A wake event is a rising edge of wake_in[i] with wake_en[i] at 1, seen through a two-flop synchroniser. It takes effect at the third clock edge after the input changes. Inputs whose enable is 0, inputs that stay high, and falling edges produce no event.
- R9: When cause_valid is 0, the first wake event sets cause_valid and loads cause_idx with the lowest index that fired in that cycle. Later events change neither output. cause_clr sampled high clears cause_valid at that edge, and the clear wins over a wake event in the same cycle.
- R10: While busy is 1, mode requests are ignored.
- R11: In normal mode, irq and wake events leave the mode and all enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 3 | Requested mode code |
| core_low_freq | input | 1 | Core is at the low-frequency setting |
| irq | input | 1 | Interrupt line (synchronous) |
| wake_in | input | 37 | Asynchronous wake inputs |
| wake_en | input | 37 | Per-input wake enable |
| settle_cycles | input | 8 | Reboot settle count |
| cause_clr | input | 1 | Clear the wake cause |
| cpu_clk_en | output | 1 | CPU clock enable |
| pll_en | output | 1 | PLL enable |
| lv_supply_en | output | 1 | Low-voltage supply enable |
| hv_supply_en | output | 1 | High-voltage supply enable |
| reboot_req | output | 1 | Restart fetch from address zero |
| busy | output | 1 | Exit sequence in progress |
| cur_mode | output | 3 | Current mode code |
| cause_valid | output | 1 | A wake cause is held |
| cause_idx | output | 6 | Index of the waking input |

## Verification
A request, an irq and a cause clear each take effect at the first clock edge that samples them. A wake input takes effect at the third edge after it changes: two edges pass through the synchroniser and one edge through the edge detector. After a wake from sleep or deep sleep, the settle phase runs for L+1 cycles and pll_en rises in the second of those cycles. The bench drives inputs on falling edges and files each expectation under the exact cycle number at which it falls due. Each wake test also checks the cycle before the change, which catches a result that arrives a cycle early as well as one that arrives late.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power mode sequencer.
// Assumes: mode codes are visible to software and must stay fixed.
package lpm_pkg;

    // Software-visible mode codes.
    typedef enum logic [2:0] {
        M_NORMAL  = 3'd0,
        M_IDLE    = 3'd1,
        M_DIDLE   = 3'd2,
        M_STANDBY = 3'd3,
        M_SLEEP   = 3'd4,
        M_DSLEEP  = 3'd5
    } lpm_mode_e;

    // Internal sequencer states: the six modes plus the reboot settle phase.
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_DIDLE  = 3'd2,
        ST_STBY   = 3'd3,
        ST_SLEEP  = 3'd4,
        ST_DSLEEP = 3'd5,
        ST_SETTLE = 3'd6
    } lpm_state_e;

endpackage

// File: rtl/lpm_wake_sync.sv
// Synchronises asynchronous wake inputs through two flops and reports
// enabled rising edges as one-cycle event pulses.
// Assumes: wake_en is quasi-static and already in the clk domain.
module lpm_wake_sync #(
    parameter int NWAKE = 37
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NWAKE-1:0] wake_in,
    input  logic [NWAKE-1:0] wake_en,
    output logic [NWAKE-1:0] wake_evt,
    output logic             wake_any
);

    logic [NWAKE-1:0] meta_q;
    logic [NWAKE-1:0] sync_q;
    logic [NWAKE-1:0] prev_q;

    genvar gi;
    generate
        for (gi = 0; gi < NWAKE; gi++) begin : g_bit
            // Per input: two synchroniser stages and one history stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q[gi] <= 1'b0;
                    sync_q[gi] <= 1'b0;
                    prev_q[gi] <= 1'b0;
                end else begin
                    meta_q[gi] <= wake_in[gi];
                    sync_q[gi] <= meta_q[gi];
                    prev_q[gi] <= sync_q[gi];
                end
            end
            // Enabled rising edge of the synchronised level.
            assign wake_evt[gi] = sync_q[gi] & ~prev_q[gi] & wake_en[gi];
        end
    endgenerate

    // Any enabled wake event this cycle.
    assign wake_any = |wake_evt;

    // R8: an event on an input cannot repeat in the next cycle.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ((wake_evt & $past(wake_evt)) == '0));

endmodule

// File: rtl/lpm_cause_reg.sv
// Holds the index of the first wake event until software clears it.
// Assumes: the lowest index wins when several events fire together.
module lpm_cause_reg #(
    parameter int NWAKE = 37,
    localparam int IDX_W = $clog2(NWAKE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NWAKE-1:0] wake_evt,
    input  logic             cause_clr,
    output logic             cause_valid,
    output logic [IDX_W-1:0] cause_idx
);

    logic [IDX_W-1:0] first_idx;

    // Lowest-index priority encoder over this cycle's events.
    always_comb begin
        first_idx = '0;
        for (int i = NWAKE - 1; i >= 0; i--) begin
            if (wake_evt[i]) first_idx = IDX_W'(i);
        end
    end

    // Capture the first event; a clear takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_valid <= 1'b0;
            cause_idx   <= '0;
        end else if (cause_clr) begin
            cause_valid <= 1'b0;
        end else if (!cause_valid && (|wake_evt)) begin
            cause_valid <= 1'b1;
            cause_idx   <= first_idx;
        end
    end

    // R9: a held cause stays put until cleared.
    a_r9_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_valid && !cause_clr) |=> (cause_valid && $stable(cause_idx)));

    // R9: a clear always empties the register.
    a_r9_cause_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cause_clr |=> !cause_valid);

endmodule

// File: rtl/lpm_mode_fsm.sv
// Mode sequencer: accepts requests in normal mode, drives clock and supply
// enables per mode, and runs the reboot settle phase after sleep exits.
// Assumes: irq is synchronous to clk; wake_any is a one-cycle pulse.
module lpm_mode_fsm
    import lpm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_mode,
    input  logic             core_low_freq,
    input  logic             irq,
    input  logic             wake_any,
    input  logic [CNT_W-1:0] settle_cycles,
    output logic             cpu_clk_en,
    output logic             pll_en,
    output logic             lv_en,
    output logic             hv_en,
    output logic             reboot_req,
    output logic             busy,
    output logic [2:0]       cur_mode
);

    lpm_state_e       st_q, st_d;
    lpm_mode_e        src_q, src_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim;

    // Settle limit, never below one so the PLL rises before release.
    assign lim = (settle_cycles == '0) ? CNT_W'(1) : settle_cycles;

    // Next-state selection.
    always_comb begin
        st_d  = st_q;
        src_d = src_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_RUN: begin
                if (req_valid) begin
                    case (req_mode)
                        M_IDLE:    st_d = ST_IDLE;
                        M_DIDLE:   if (core_low_freq) st_d = ST_DIDLE;
                        M_STANDBY: st_d = ST_STBY;
                        M_SLEEP:   st_d = ST_SLEEP;
                        M_DSLEEP:  st_d = ST_DSLEEP;
                        default:   st_d = ST_RUN;
                    endcase
                end
            end
            ST_IDLE, ST_DIDLE: begin
                if (irq || wake_any) st_d = ST_RUN;
            end
            ST_STBY: begin
                if (wake_any) st_d = ST_RUN;
            end
            ST_SLEEP, ST_DSLEEP: begin
                if (wake_any) begin
                    st_d  = ST_SETTLE;
                    cnt_d = '0;
                    src_d = (st_q == ST_SLEEP) ? M_SLEEP : M_DSLEEP;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == lim) st_d = ST_RUN;
                else              cnt_d = cnt_q + CNT_W'(1);
            end
            default: st_d = ST_RUN;
        endcase
    end

    // State, settle counter and left-mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            src_q <= M_NORMAL;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            src_q <= src_d;
            cnt_q <= cnt_d;
        end
    end

    // Output decode per state.
    always_comb begin
        cpu_clk_en = 1'b0;
        pll_en     = 1'b0;
        lv_en      = 1'b1;
        hv_en      = 1'b1;
        reboot_req = 1'b0;
        busy       = 1'b0;
        cur_mode   = M_NORMAL;
        unique case (st_q)
            ST_RUN: begin
                cpu_clk_en = 1'b1;
                pll_en     = 1'b1;
            end
            ST_IDLE: begin
                pll_en   = 1'b1;
                cur_mode = M_IDLE;
            end
            ST_DIDLE: begin
                pll_en   = 1'b1;
                cur_mode = M_DIDLE;
            end
            ST_STBY: cur_mode = M_STANDBY;
            ST_SLEEP: begin
                lv_en    = 1'b0;
                cur_mode = M_SLEEP;
            end
            ST_DSLEEP: begin
                lv_en    = 1'b0;
                hv_en    = 1'b0;
                cur_mode = M_DSLEEP;
            end
            ST_SETTLE: begin
                pll_en     = (cnt_q != '0);
                reboot_req = 1'b1;
                busy       = 1'b1;
                cur_mode   = src_q;
            end
            default: cur_mode = M_NORMAL;
        endcase
    end

    // R4: a deep-idle request at high frequency leaves the block running.
    a_r4_didle_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && req_valid && req_mode == 3'd2 && !core_low_freq)
        |=> (st_q == ST_RUN));

    // R3: an interrupt in idle resumes at the next edge.
    a_r3_idle_resume: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE || st_q == ST_DIDLE) && irq) |=> (st_q == ST_RUN));

    // R7: the PLL is already on when the reboot request is released.
    a_r7_pll_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reboot_req) |-> $past(pll_en));

    // R7: a wake from a sleep mode enters the settle phase.
    a_r7_wake_settle: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SLEEP || st_q == ST_DSLEEP) && wake_any) |=> reboot_req);

endmodule

// File: rtl/lpm_sequencer.sv
// Top of the low-power mode sequencer: wake synchroniser, cause register
// and mode state machine.
// Assumes: one clock domain; wake_in asynchronous, everything else synchronous.
module lpm_sequencer #(
    parameter int NWAKE = 37,
    parameter int CNT_W = 8,
    localparam int IDX_W = $clog2(NWAKE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_mode,
    input  logic             core_low_freq,
    input  logic             irq,
    input  logic [NWAKE-1:0] wake_in,
    input  logic [NWAKE-1:0] wake_en,
    input  logic [CNT_W-1:0] settle_cycles,
    input  logic             cause_clr,
    output logic             cpu_clk_en,
    output logic             pll_en,
    output logic             lv_supply_en,
    output logic             hv_supply_en,
    output logic             reboot_req,
    output logic             busy,
    output logic [2:0]       cur_mode,
    output logic             cause_valid,
    output logic [IDX_W-1:0] cause_idx
);

    logic [NWAKE-1:0] wake_evt;
    logic             wake_any;

    lpm_wake_sync #(.NWAKE(NWAKE)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_in  (wake_in),
        .wake_en  (wake_en),
        .wake_evt (wake_evt),
        .wake_any (wake_any)
    );

    lpm_cause_reg #(.NWAKE(NWAKE)) u_cause (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_evt    (wake_evt),
        .cause_clr   (cause_clr),
        .cause_valid (cause_valid),
        .cause_idx   (cause_idx)
    );

    lpm_mode_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_mode      (req_mode),
        .core_low_freq (core_low_freq),
        .irq           (irq),
        .wake_any      (wake_any),
        .settle_cycles (settle_cycles),
        .cpu_clk_en    (cpu_clk_en),
        .pll_en        (pll_en),
        .lv_en         (lv_supply_en),
        .hv_en         (hv_supply_en),
        .reboot_req    (reboot_req),
        .busy          (busy),
        .cur_mode      (cur_mode)
    );

    // R10: once busy, the block either stays busy or lands in normal.
    a_r10_busy_to_normal: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || cur_mode == 3'd0));

    // R6: with the low-voltage rail off, clocks and PLL are off.
    a_r6_rail_order: assert property (@(posedge clk) disable iff (!rst_n)
        !lv_supply_en |-> (!cpu_clk_en && !pll_en));

endmodule

// File: tb/sim_lpm_sequencer.sv
// Scoreboard bench: the driver files expected snapshots under a cycle
// number, and the monitor compares them on the falling edge of that cycle.
module sim_lpm_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 37;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_mode = 3'd0;
    logic          core_low_freq = 1'b0;
    logic          irq = 1'b0;
    logic [NW-1:0] wake_in = '0;
    logic [NW-1:0] wake_en = '0;
    logic [7:0]    settle_cycles = 8'd3;
    logic          cause_clr = 1'b0;
    logic cpu_clk_en, pll_en, lv_supply_en, hv_supply_en, reboot_req, busy, cause_valid;
    logic [2:0] cur_mode;
    logic [5:0] cause_idx;

    lpm_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .core_low_freq(core_low_freq), .irq(irq), .wake_in(wake_in),
        .wake_en(wake_en), .settle_cycles(settle_cycles), .cause_clr(cause_clr),
        .cpu_clk_en(cpu_clk_en), .pll_en(pll_en), .lv_supply_en(lv_supply_en),
        .hv_supply_en(hv_supply_en), .reboot_req(reboot_req), .busy(busy),
        .cur_mode(cur_mode), .cause_valid(cause_valid), .cause_idx(cause_idx)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int          cyc;
        logic [15:0] val;
        string       tag;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    n_tests = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    logic        exp_cv = 1'b0;
    logic [5:0]  exp_ci = '0;

    wire [15:0] obs = {cur_mode, cpu_clk_en, pll_en, lv_supply_en, hv_supply_en,
                       reboot_req, busy, cause_valid, cause_idx};

    // Counts rising edges.
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops and compares every expectation due this cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            n_tests++;
            if (sb[0].cyc < cyc) begin
                n_fail++;
                $display("FAIL %s: missed cycle %0d", sb[0].tag, sb[0].cyc);
            end else if (obs !== sb[0].val) begin
                n_fail++;
                $display("FAIL %s @%0d: actual %h expected %h", sb[0].tag, cyc, obs, sb[0].val);
            end
            void'(sb.pop_front());
        end
    end

    // Rails {cpu, pll, lv, hv} for each stable mode.
    function automatic logic [3:0] rails(logic [2:0] m);
        case (m)
            3'd0:       return 4'b1111;
            3'd1, 3'd2: return 4'b0111;
            3'd3:       return 4'b0011;
            3'd4:       return 4'b0001;
            default:    return 4'b0000;
        endcase
    endfunction

    // Driver side: file an expectation d cycles ahead, kept in cycle order.
    task automatic want(int d, logic [2:0] m, logic [3:0] r, logic rb, logic bz, string tag);
        item_t it;
        int pos;
        it.cyc = cyc + d;
        it.val = {m, r, rb, bz, exp_cv, exp_ci};
        it.tag = tag;
        pos = sb.size();
        while (pos > 0 && sb[pos-1].cyc > it.cyc) pos--;
        sb.insert(pos, it);
    endtask

    task automatic stable(int d, logic [2:0] m, string tag);
        want(d, m, rails(m), 1'b0, 1'b0, tag);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(logic [2:0] m, logic [2:0] exp_m, string tag);
        req_valid = 1'b1;
        req_mode  = m;
        stable(1, exp_m, tag);
        tick(1);
        req_valid = 1'b0;
        tick(1);
    endtask

    task automatic clear_cause(string tag);
        cause_clr = 1'b1;
        exp_cv = 1'b0;
        stable(1, 3'd0, tag);
        tick(1);
        cause_clr = 1'b0;
        tick(1);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        stable(1, 3'd0, "R1 reset state");
        tick(2);

        // Idle entry and interrupt resume.
        request(3'd1, 3'd1, "R2 enter idle");
        irq = 1'b1;
        stable(1, 3'd0, "R3 irq leaves idle");
        tick(1);
        irq = 1'b0;
        tick(1);

        // Unused codes are ignored.
        request(3'd7, 3'd0, "R2 code 7 ignored");
        request(3'd0, 3'd0, "R2 code 0 no change");

        // Deep idle refused at high frequency, granted at low frequency.
        core_low_freq = 1'b0;
        request(3'd2, 3'd0, "R4 deep idle refused");
        core_low_freq = 1'b1;
        request(3'd2, 3'd2, "R4 deep idle granted");
        wake_en = '1;
        wake_en[7] = 1'b0;
        wake_en[3] = 1'b0;
        wake_in[0] = 1'b1;
        stable(2, 3'd2, "R8 no early wake");
        exp_cv = 1'b1; exp_ci = 6'd0;
        stable(3, 3'd0, "R3 wake leaves deep idle");
        tick(4);
        wake_in[0] = 1'b0;
        tick(3);
        clear_cause("R9 clear after deep idle");

        // Standby: irq ignored, wake resumes without reboot.
        request(3'd3, 3'd3, "R5 enter standby");
        irq = 1'b1;
        stable(1, 3'd3, "R5 irq ignored in standby");
        tick(1);
        irq = 1'b0;
        wake_in[10] = 1'b1;
        stable(2, 3'd3, "R8 standby before wake");
        exp_cv = 1'b1; exp_ci = 6'd10;
        stable(3, 3'd0, "R5 wake leaves standby");
        tick(4);
        wake_in[10] = 1'b0;
        tick(3);
        clear_cause("R9 clear after standby");

        // Sleep with settle_cycles = 3, request ignored while busy.
        settle_cycles = 8'd3;
        request(3'd4, 3'd4, "R6 enter sleep");
        irq = 1'b1;
        stable(1, 3'd4, "R6 irq ignored in sleep");
        tick(1);
        irq = 1'b0;
        wake_in[36] = 1'b1;
        stable(2, 3'd4, "R8 sleep before wake");
        exp_cv = 1'b1; exp_ci = 6'd36;
        want(3, 3'd4, 4'b0011, 1'b1, 1'b1, "R7 settle first cycle");
        want(4, 3'd4, 4'b0111, 1'b1, 1'b1, "R7 pll up in settle");
        want(6, 3'd4, 4'b0111, 1'b1, 1'b1, "R10 request ignored while busy");
        stable(7, 3'd0, "R7 settle ends in normal");
        tick(4);
        req_valid = 1'b1;
        req_mode = 3'd1;
        tick(1);
        req_valid = 1'b0;
        tick(3);
        wake_in[36] = 1'b0;
        tick(3);

        // Normal mode ignores irq and wake; held cause not overwritten.
        irq = 1'b1;
        stable(1, 3'd0, "R11 irq in normal");
        tick(1);
        irq = 1'b0;
        wake_in[2] = 1'b1;
        stable(3, 3'd0, "R9 R11 later wake keeps cause");
        tick(4);
        wake_in[2] = 1'b0;
        tick(3);
        clear_cause("R9 clear before deep sleep");

        // Deep sleep with settle_cycles = 0 (limit 1).
        settle_cycles = 8'd0;
        request(3'd5, 3'd5, "R6 enter deep sleep");
        wake_in[3] = 1'b1;
        stable(3, 3'd5, "R8 disabled input ignored");
        tick(4);
        wake_in[20] = 1'b1;
        wake_in[5]  = 1'b1;
        stable(2, 3'd5, "R8 deep sleep before wake");
        exp_cv = 1'b1; exp_ci = 6'd5;
        want(3, 3'd5, 4'b0011, 1'b1, 1'b1, "R7 R9 settle zero first cycle");
        want(4, 3'd5, 4'b0111, 1'b1, 1'b1, "R7 settle zero pll up");
        stable(5, 3'd0, "R7 settle zero ends");
        tick(6);
        stable(1, 3'd0, "R8 held level no retrigger");
        tick(2);

        // Clear wins over a same-cycle event.
        wake_in[20] = 1'b0;
        wake_in[5]  = 1'b0;
        tick(3);
        wake_in[9] = 1'b1;
        tick(2);
        cause_clr = 1'b1;
        exp_cv = 1'b0;
        stable(1, 3'd0, "R9 clear beats event");
        tick(1);
        cause_clr = 1'b0;
        tick(3);

        while (sb.size() > 0) tick(1);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule